// File: doc/BRIEF.md
# Fixed-Point Integer ALU with Status Flag Generation

This block executes one 64-bit fixed-point integer operation per clock: add, subtract-from, their carrying and extended variants, add-to-zero-extended, negate, an add that carries through the overflow bit, compare, and the register and immediate logical operations. Alongside the result it produces the status updates that the operation defines: carry and its low-half copy, overflow and its low-half copy, the sticky summary overflow, and a four-bit condition field with less-than, greater-than, equal and summary-overflow bits.

The issuing logic supplies the operation code, both operands (the immediate already placed in operand B), the current carry, overflow and summary-overflow bits, the overflow-enable and record flags, the extended-carry select for the overflow-carrying add, and the compare controls. One clock later the block returns the result and each flag group with its own write-enable, so the register files and status register can be updated selectively. A flag value reads zero whenever its write-enable is low.

Top module: `fxu_alu`

## Requirements
- R1: All outputs are registered one clock after the inputs; an active-low asynchronous reset drives every output to zero, and every flag value output is zero in any cycle where its write-enable is low.
- R2: Arithmetic results: code 0 gives A+B, 1 gives A+B, 2 gives NOT(A)+B+1, 3 gives NOT(A)+B+1, 4 gives A+B+CA, 5 gives NOT(A)+B+CA, 6 gives A+CA, 7 gives NOT(A)+1, 8 gives A+B+OV, all modulo 2^64, with the result write-enable set.
- R3: For codes 0 to 7 the overflow group (OV, OV32) is written only when the overflow-enable flag is 1; OV is the signed 64-bit overflow of the sum and OV32 the signed overflow of the low 32-bit half.
- R4: Summary overflow is written exactly when the overflow group is written by codes 0 to 7, and its new value is the incoming summary bit ORed with the new OV, so it never goes from 1 to 0.
- R5: Codes 1, 3, 4, 5 and 6 write carry: CA is the carry out of bit 63 and CA32 the carry out of the low 32-bit half; no other code writes carry.
- R6: Code 8 takes the incoming OV as carry-in, never writes CA or summary overflow, and ignores the overflow-enable and record flags; when the extended-carry select is 1 it writes the carry out of bit 63 into OV and the low-half carry into OV32, and when it is 0 it writes no overflow bits.
- R7: With the record flag set, codes 0 to 7 and 10 to 16 write condition field 0 with bits {LT,GT,EQ,SO} (LT most significant) taken from the signed result (negative, positive non-zero, zero) and SO equal to the summary overflow after this operation.
- R8: Code 9 compares A with B, signed or unsigned, over the full 64 bits or the low 32 bits, writes exactly one of LT, GT, EQ into the selected condition field with SO copied from the incoming summary bit, and does not write a result.
- R9: Codes 10 to 16 give A AND B, A OR B, A XOR B, NOT(A AND B), NOT(A XOR B), A AND NOT B, A OR NOT B, writing the result but no carry or overflow; codes 18 to 31 write nothing.
- R10: Code 17 gives A AND B and always writes condition field 0, whatever the record flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opCode | input | 5 | Operation code |
| opA | input | 64 | Operand A |
| opB | input | 64 | Operand B or prepared immediate |
| oeFlag | input | 1 | Overflow-enable flag |
| rcFlag | input | 1 | Record flag for condition field 0 |
| cyField | input | 1 | Extended-carry select for code 8 |
| cmpSigned | input | 1 | Compare as signed when 1 |
| cmpWord | input | 1 | Compare low 32 bits when 1 |
| cmpField | input | 3 | Target condition field for compare |
| xerSoIn | input | 1 | Incoming summary overflow |
| xerOvIn | input | 1 | Incoming overflow |
| xerCaIn | input | 1 | Incoming carry |
| result | output | 64 | Operation result |
| resultWe | output | 1 | Result write-enable |
| caOut | output | 1 | New carry |
| ca32Out | output | 1 | New low-half carry |
| caWe | output | 1 | Carry group write-enable |
| ovOut | output | 1 | New overflow |
| ov32Out | output | 1 | New low-half overflow |
| ovWe | output | 1 | Overflow group write-enable |
| soOut | output | 1 | New summary overflow |
| soWe | output | 1 | Summary overflow write-enable |
| crBits | output | 4 | Condition bits {LT,GT,EQ,SO} |
| crWe | output | 1 | Condition field write-enable |
| crFieldSel | output | 3 | Condition field index |

## Verification
A wrong decode strobe in this block shows up as a write-enable raised or dropped for one operation code, visible at the ports on the very next clock for any operand pair. A fault in the split carry chain or in operand conditioning corrupts the result or CA32/OV32 only for operands that cross the 32-bit or sign boundary, which is why the stimulus mixes the extreme values with random data and every output is compared on every clock. A stale summary bit surfaces in both the summary output and the SO bit of the condition field in the same cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 5'd0,
    OP_ADDC   = 5'd1,
    OP_SUBF   = 5'd2,
    OP_SUBFC  = 5'd3,
    OP_ADDE   = 5'd4,
    OP_SUBFE  = 5'd5,
    OP_ADDZE  = 5'd6,
    OP_NEG    = 5'd7,
    OP_ADDEX  = 5'd8,
    OP_CMP    = 5'd9,
    OP_AND    = 5'd10,
    OP_OR     = 5'd11,
    OP_XOR    = 5'd12,
    OP_NAND   = 5'd13,
    OP_EQV    = 5'd14,
    OP_ANDC   = 5'd15,
    OP_ORC    = 5'd16,
    OP_ANDIMM = 5'd17
  } aluOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_CA,
    CIN_OV
  } cinSel_e;

  typedef enum logic [2:0] {
    LG_AND,
    LG_OR,
    LG_XOR,
    LG_NAND,
    LG_EQV,
    LG_ANDC,
    LG_ORC
  } logicSel_e;

  typedef struct packed {
    logic      invA;
    logic      zeroB;
    cinSel_e   cinSel;
    logic      isLogic;
    logicSel_e logicSel;
    logic      isCmp;
    logic      wrResult;
    logic      wrCa;
    logic      wrOv;
    logic      ovFromCarry;
    logic      wrSo;
    logic      wrCr;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  input  logic            oeFlag,
  input  logic            rcFlag,
  input  logic            cyField,
  output aluStrobe_t      strobe
);

  logic arithOp;
  logic logicOp;

  always_comb begin
    strobe          = '0;
    strobe.cinSel   = CIN_ZERO;
    strobe.logicSel = LG_AND;
    arithOp         = 1'b0;
    logicOp         = 1'b0;
    unique case (aluOp_e'(opCode))
      OP_ADD:   arithOp = 1'b1;
      OP_ADDC: begin
        arithOp     = 1'b1;
        strobe.wrCa = 1'b1;
      end
      OP_SUBF: begin
        arithOp       = 1'b1;
        strobe.invA   = 1'b1;
        strobe.cinSel = CIN_ONE;
      end
      OP_SUBFC: begin
        arithOp       = 1'b1;
        strobe.invA   = 1'b1;
        strobe.cinSel = CIN_ONE;
        strobe.wrCa   = 1'b1;
      end
      OP_ADDE: begin
        arithOp       = 1'b1;
        strobe.cinSel = CIN_CA;
        strobe.wrCa   = 1'b1;
      end
      OP_SUBFE: begin
        arithOp       = 1'b1;
        strobe.invA   = 1'b1;
        strobe.cinSel = CIN_CA;
        strobe.wrCa   = 1'b1;
      end
      OP_ADDZE: begin
        arithOp       = 1'b1;
        strobe.zeroB  = 1'b1;
        strobe.cinSel = CIN_CA;
        strobe.wrCa   = 1'b1;
      end
      OP_NEG: begin
        arithOp       = 1'b1;
        strobe.invA   = 1'b1;
        strobe.zeroB  = 1'b1;
        strobe.cinSel = CIN_ONE;
      end
      OP_ADDEX: begin
        strobe.wrResult    = 1'b1;
        strobe.cinSel      = CIN_OV;
        strobe.wrOv        = cyField;
        strobe.ovFromCarry = cyField;
      end
      OP_CMP: begin
        strobe.isCmp = 1'b1;
        strobe.wrCr  = 1'b1;
      end
      OP_AND:  begin logicOp = 1'b1; strobe.logicSel = LG_AND;  end
      OP_OR:   begin logicOp = 1'b1; strobe.logicSel = LG_OR;   end
      OP_XOR:  begin logicOp = 1'b1; strobe.logicSel = LG_XOR;  end
      OP_NAND: begin logicOp = 1'b1; strobe.logicSel = LG_NAND; end
      OP_EQV:  begin logicOp = 1'b1; strobe.logicSel = LG_EQV;  end
      OP_ANDC: begin logicOp = 1'b1; strobe.logicSel = LG_ANDC; end
      OP_ORC:  begin logicOp = 1'b1; strobe.logicSel = LG_ORC;  end
      OP_ANDIMM: begin
        strobe.isLogic  = 1'b1;
        strobe.wrResult = 1'b1;
        strobe.logicSel = LG_AND;
        strobe.wrCr     = 1'b1;
      end
      default: ;
    endcase

    if (arithOp) begin
      strobe.wrResult = 1'b1;
      strobe.wrOv     = oeFlag;
      strobe.wrSo     = oeFlag;
      strobe.wrCr     = rcFlag;
    end
    if (logicOp) begin
      strobe.isLogic  = 1'b1;
      strobe.wrResult = 1'b1;
      strobe.wrCr     = rcFlag;
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              cmpSigned,
  input  logic              cmpWord,
  input  logic [2:0]        cmpField,
  input  logic              xerSoIn,
  input  logic              xerOvIn,
  input  logic              xerCaIn,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic              caOut,
  output logic              ca32Out,
  output logic              caWe,
  output logic              ovOut,
  output logic              ov32Out,
  output logic              ovWe,
  output logic              soOut,
  output logic              soWe,
  output logic [3:0]        crBits,
  output logic              crWe,
  output logic [2:0]        crFieldSel
);

  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;
  localparam int HMSB   = HALF_W - 1;

  logic [DATA_W-1:0] effA, effB, sumVal, logicVal, nextResult;
  logic              carryIn;
  logic [HALF_W:0]   sumLo, sumHi;
  logic              carryOut, carryHalf, ovFull, ovHalf;
  logic              ovVal, ov32Val, soNew, soForCr;
  logic signed [DATA_W:0] cmpA, cmpB;
  logic              cmpLt, cmpGt, cmpEq;
  logic [3:0]        crVal;

  // operand conditioning
  always_comb begin
    effA = strobe.invA  ? ~opA : opA;
    effB = strobe.zeroB ? '0   : opB;
    unique case (strobe.cinSel)
      CIN_ONE: carryIn = 1'b1;
      CIN_CA:  carryIn = xerCaIn;
      CIN_OV:  carryIn = xerOvIn;
      default: carryIn = 1'b0;
    endcase
  end

  // adder split at the half boundary to expose the low-half carry
  always_comb begin
    sumLo     = {1'b0, effA[HMSB:0]} + {1'b0, effB[HMSB:0]} + {{HALF_W{1'b0}}, carryIn};
    sumHi     = {1'b0, effA[MSB:HALF_W]} + {1'b0, effB[MSB:HALF_W]} + {{HALF_W{1'b0}}, sumLo[HALF_W]};
    sumVal    = {sumHi[HMSB:0], sumLo[HMSB:0]};
    carryOut  = sumHi[HALF_W];
    carryHalf = sumLo[HALF_W];
    ovFull    = (effA[MSB] == effB[MSB]) && (sumVal[MSB] != effA[MSB]);
    ovHalf    = (effA[HMSB] == effB[HMSB]) && (sumVal[HMSB] != effA[HMSB]);
  end

  always_comb begin
    unique case (strobe.logicSel)
      LG_OR:   logicVal = opA | opB;
      LG_XOR:  logicVal = opA ^ opB;
      LG_NAND: logicVal = ~(opA & opB);
      LG_EQV:  logicVal = ~(opA ^ opB);
      LG_ANDC: logicVal = opA & ~opB;
      LG_ORC:  logicVal = opA | ~opB;
      default: logicVal = opA & opB;
    endcase
  end

  // comparison over a widened signed range covers both signednesses
  always_comb begin
    if (cmpWord) begin
      cmpA = {{(HALF_W + 1){cmpSigned & opA[HMSB]}}, opA[HMSB:0]};
      cmpB = {{(HALF_W + 1){cmpSigned & opB[HMSB]}}, opB[HMSB:0]};
    end else begin
      cmpA = {cmpSigned & opA[MSB], opA};
      cmpB = {cmpSigned & opB[MSB], opB};
    end
    cmpLt = cmpA < cmpB;
    cmpGt = cmpA > cmpB;
    cmpEq = cmpA == cmpB;
  end

  always_comb begin
    if (!strobe.wrResult)   nextResult = '0;
    else if (strobe.isLogic) nextResult = logicVal;
    else                     nextResult = sumVal;
    ovVal   = strobe.ovFromCarry ? carryOut  : ovFull;
    ov32Val = strobe.ovFromCarry ? carryHalf : ovHalf;
    soNew   = xerSoIn | ovVal;
    soForCr = strobe.wrSo ? soNew : xerSoIn;
    if (strobe.isCmp)
      crVal = {cmpLt, cmpGt, cmpEq, xerSoIn};
    else
      crVal = {nextResult[MSB], !nextResult[MSB] && (nextResult != '0),
               nextResult == '0, soForCr};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result     <= '0;
      resultWe   <= 1'b0;
      caOut      <= 1'b0;
      ca32Out    <= 1'b0;
      caWe       <= 1'b0;
      ovOut      <= 1'b0;
      ov32Out    <= 1'b0;
      ovWe       <= 1'b0;
      soOut      <= 1'b0;
      soWe       <= 1'b0;
      crBits     <= '0;
      crWe       <= 1'b0;
      crFieldSel <= '0;
    end else begin
      result     <= nextResult;
      resultWe   <= strobe.wrResult;
      caOut      <= strobe.wrCa & carryOut;
      ca32Out    <= strobe.wrCa & carryHalf;
      caWe       <= strobe.wrCa;
      ovOut      <= strobe.wrOv & ovVal;
      ov32Out    <= strobe.wrOv & ov32Val;
      ovWe       <= strobe.wrOv;
      soOut      <= strobe.wrSo & soNew;
      soWe       <= strobe.wrSo;
      crBits     <= strobe.wrCr ? crVal : 4'b0000;
      crWe       <= strobe.wrCr;
      crFieldSel <= (strobe.wrCr && strobe.isCmp) ? cmpField : 3'd0;
    end
  end

endmodule

// File: rtl/fxu_alu.sv
module fxu_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              oeFlag,
  input  logic              rcFlag,
  input  logic              cyField,
  input  logic              cmpSigned,
  input  logic              cmpWord,
  input  logic [2:0]        cmpField,
  input  logic              xerSoIn,
  input  logic              xerOvIn,
  input  logic              xerCaIn,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic              caOut,
  output logic              ca32Out,
  output logic              caWe,
  output logic              ovOut,
  output logic              ov32Out,
  output logic              ovWe,
  output logic              soOut,
  output logic              soWe,
  output logic [3:0]        crBits,
  output logic              crWe,
  output logic [2:0]        crFieldSel
);

  aluStrobe_t strobe;

  alu_ctrl u_ctrl (
    .opCode  (opCode),
    .oeFlag  (oeFlag),
    .rcFlag  (rcFlag),
    .cyField (cyField),
    .strobe  (strobe)
  );

  alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opA        (opA),
    .opB        (opB),
    .cmpSigned  (cmpSigned),
    .cmpWord    (cmpWord),
    .cmpField   (cmpField),
    .xerSoIn    (xerSoIn),
    .xerOvIn    (xerOvIn),
    .xerCaIn    (xerCaIn),
    .result     (result),
    .resultWe   (resultWe),
    .caOut      (caOut),
    .ca32Out    (ca32Out),
    .caWe       (caWe),
    .ovOut      (ovOut),
    .ov32Out    (ov32Out),
    .ovWe       (ovWe),
    .soOut      (soOut),
    .soWe       (soWe),
    .crBits     (crBits),
    .crWe       (crWe),
    .crFieldSel (crFieldSel)
  );

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        opCode,
  input logic              oeFlag,
  input logic              cyField,
  input logic              xerSoIn,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic              caWe,
  input logic              ovWe,
  input logic              soOut,
  input logic              soWe,
  input logic [3:0]        crBits,
  input logic              crWe
);

  // R3: without overflow-enable, codes 0..7 leave the overflow group alone
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(oeFlag) && $past(opCode) <= 5'd7) |-> !ovWe);

  // R4: summary overflow never falls while it is being written
  p_sticky_so_r4: assert property (@(posedge clk) disable iff (!rstN)
    (soWe && $past(xerSoIn)) |-> soOut);

  // R6: the overflow-carrying add never touches carry or summary overflow
  p_addex_no_ca_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opCode) == 5'd8) |-> (!caWe && !soWe));

  // R6: with the select clear, no overflow write
  p_addex_cy0_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opCode) == 5'd8 && !$past(cyField)) |-> !ovWe);

  // R7 and R8: a written condition field holds exactly one relation bit
  p_cr_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    crWe |-> ($countones(crBits[3:1]) == 1));

  // R7: equal bit agrees with a zero result
  p_cr0_eq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (crWe && resultWe) |-> (crBits[1] == (result == '0)));

  // R9: logical codes write no carry and no overflow
  p_logic_noflag_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opCode) >= 5'd10 && $past(opCode) <= 5'd17) |-> (!caWe && !ovWe));

  // R10: the immediate AND always records
  p_andimm_cr_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(opCode) == 5'd17) |-> crWe);

endmodule

bind fxu_alu alu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fxu_alu_bench.sv
`timescale 1ns/1ps
module fxu_alu_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  opCode = '0;
  logic [63:0] opA = '0, opB = '0;
  logic        oeFlag = 0, rcFlag = 0, cyField = 0, cmpSigned = 0, cmpWord = 0;
  logic [2:0]  cmpField = '0;
  logic        xerSoIn = 0, xerOvIn = 0, xerCaIn = 0;

  logic [63:0] result;
  logic        resultWe, caOut, ca32Out, caWe, ovOut, ov32Out, ovWe, soOut, soWe, crWe;
  logic [3:0]  crBits;
  logic [2:0]  crFieldSel;

  always #4 clk = ~clk;

  fxu_alu u_fxu_alu (.*);

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit havePrev = 0;

  // expected values for the last applied input set
  logic [63:0] eRes;
  logic        eResWe, eCaWe, eCa, eCa32, eOvWe, eOv, eOv32, eSoWe, eSo, eCrWe;
  logic [3:0]  eCr;
  logic [2:0]  eCrSel;
  int          eOp;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%0d actual=%h expected=%h", tag, eOp, act, exp);
    end
  endtask

  task automatic model();
    int op;
    bit arith, isLog, cin;
    logic [63:0] a2, b2;
    logic [65:0] full;
    logic [32:0] lo;
    logic signed [65:0] sFull;
    logic signed [33:0] sLo;
    bit ovS, ov32S, lt, gt, eq, soAfter;
    op    = int'(opCode);
    eOp   = op;
    arith = (op <= 7);
    isLog = (op >= 10 && op <= 17);
    a2 = (op == 2 || op == 3 || op == 5 || op == 7) ? ~opA : opA;
    b2 = (op == 6 || op == 7) ? 64'd0 : opB;
    cin = 0;
    if (op == 2 || op == 3 || op == 7) cin = 1;
    if (op == 4 || op == 5 || op == 6) cin = xerCaIn;
    if (op == 8) cin = xerOvIn;
    full  = {2'b00, a2} + {2'b00, b2} + 66'(cin);
    lo    = {1'b0, a2[31:0]} + {1'b0, b2[31:0]} + 33'(cin);
    sFull = $signed({a2[63], a2[63], a2}) + $signed({b2[63], b2[63], b2}) + $signed({65'd0, cin});
    sLo   = $signed({a2[31], a2[31], a2[31:0]}) + $signed({b2[31], b2[31], b2[31:0]}) + $signed({33'd0, cin});
    ovS   = (sFull[65:63] != 3'b000) && (sFull[65:63] != 3'b111);
    ov32S = (sLo[33:31] != 3'b000) && (sLo[33:31] != 3'b111);

    eResWe = arith || op == 8 || isLog;
    eRes = 64'd0;
    if (arith || op == 8) eRes = full[63:0];
    case (op)
      10, 17: eRes = opA & opB;
      11: eRes = opA | opB;
      12: eRes = opA ^ opB;
      13: eRes = ~(opA & opB);
      14: eRes = ~(opA ^ opB);
      15: eRes = opA & ~opB;
      16: eRes = opA | ~opB;
      default: ;
    endcase

    eCaWe = (op == 1 || op == 3 || op == 4 || op == 5 || op == 6);
    eCa   = eCaWe & full[64];
    eCa32 = eCaWe & lo[32];

    eOvWe = 0; eOv = 0; eOv32 = 0;
    if (arith && oeFlag) begin eOvWe = 1; eOv = ovS; eOv32 = ov32S; end
    if (op == 8 && cyField) begin eOvWe = 1; eOv = full[64]; eOv32 = lo[32]; end

    eSoWe = arith && oeFlag;
    eSo   = eSoWe & (xerSoIn | ovS);
    soAfter = eSoWe ? eSo : xerSoIn;

    eCrWe = 0; eCrSel = 3'd0; eCr = 4'd0;
    if (op == 9) begin
      if (cmpWord) begin
        if (cmpSigned) begin
          lt = $signed(opA[31:0]) < $signed(opB[31:0]);
          gt = $signed(opA[31:0]) > $signed(opB[31:0]);
        end else begin
          lt = opA[31:0] < opB[31:0];
          gt = opA[31:0] > opB[31:0];
        end
        eq = opA[31:0] == opB[31:0];
      end else begin
        if (cmpSigned) begin
          lt = $signed(opA) < $signed(opB);
          gt = $signed(opA) > $signed(opB);
        end else begin
          lt = opA < opB;
          gt = opA > opB;
        end
        eq = opA == opB;
      end
      eCrWe = 1; eCrSel = cmpField; eCr = {lt, gt, eq, xerSoIn};
    end else if ((arith && rcFlag) || (op >= 10 && op <= 16 && rcFlag) || op == 17) begin
      eCrWe = 1;
      eCr = {eRes[63], !eRes[63] && eRes != 0, eRes == 0, soAfter};
    end
  endtask

  task automatic compareAll();
    string rTag, cTag, oTag, crTag;
    rTag  = (eOp >= 10 && eOp <= 16) ? "R9 result" : (eOp == 17 ? "R10 result" : "R2 result");
    cTag  = (eOp == 8) ? "R6 carry" : "R5 carry";
    oTag  = (eOp == 8) ? "R6 overflow" : "R3 overflow";
    crTag = (eOp == 9) ? "R8 compare" : (eOp == 17 ? "R10 cr0" : "R7 cr0");
    check({resultWe, result} == {eResWe, eRes}, rTag, result, eRes);
    check(resultWe == eResWe, "R9 result enable", 64'(resultWe), 64'(eResWe));
    check({caWe, caOut, ca32Out} == {eCaWe, eCa, eCa32}, cTag,
          64'({caWe, caOut, ca32Out}), 64'({eCaWe, eCa, eCa32}));
    check({ovWe, ovOut, ov32Out} == {eOvWe, eOv, eOv32}, oTag,
          64'({ovWe, ovOut, ov32Out}), 64'({eOvWe, eOv, eOv32}));
    check({soWe, soOut} == {eSoWe, eSo}, "R4 summary",
          64'({soWe, soOut}), 64'({eSoWe, eSo}));
    check({crWe, crFieldSel, crBits} == {eCrWe, eCrSel, eCr}, crTag,
          64'({crWe, crFieldSel, crBits}), 64'({eCrWe, eCrSel, eCr}));
  endtask

  task automatic checkReset();
    eOp = -1;
    check({result, resultWe, caOut, ca32Out, caWe, ovOut, ov32Out, ovWe, soOut, soWe,
           crBits, crWe, crFieldSel} == '0, "R1 reset",
          result | 64'({resultWe, caWe, ovWe, soWe, crWe, crBits, crFieldSel}), 64'd0);
  endtask

  task automatic apply(input int op, input logic [63:0] a, input logic [63:0] b,
                       input bit oe, input bit rc, input bit cy, input bit sgn, input bit wrd,
                       input logic [2:0] fld, input bit so, input bit ov, input bit ca);
    @(negedge clk);
    if (havePrev) compareAll();
    opCode = 5'(op); opA = a; opB = b; oeFlag = oe; rcFlag = rc; cyField = cy;
    cmpSigned = sgn; cmpWord = wrd; cmpField = fld; xerSoIn = so; xerOvIn = ov; xerCaIn = ca;
    model();
    havePrev = 1;
  endtask

  function automatic logic [63:0] pick();
    case ($urandom_range(0, 9))
      0: return 64'd0;
      1: return '1;
      2: return 64'h8000_0000_0000_0000;
      3: return 64'h7fff_ffff_ffff_ffff;
      4: return 64'h0000_0000_8000_0000;
      5: return 64'h0000_0000_7fff_ffff;
      6: return 64'h0000_0000_ffff_ffff;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  localparam logic [63:0] MAXP = 64'h7fff_ffff_ffff_ffff;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;

  initial begin
    // R1: inputs during reset have no effect
    opCode = 5'd0; opA = '1; opB = 64'd1; oeFlag = 1; rcFlag = 1;
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;

    // directed corners
    apply(0, MAXP, 64'd1, 1, 1, 0, 0, 0, 0, 0, 0, 0);   // R3 overflow to negative
    apply(0, MAXP, 64'd1, 1, 1, 0, 0, 0, 0, 1, 0, 0);   // R4 sticky stays set
    apply(1, '1, 64'd1, 0, 1, 0, 0, 0, 0, 0, 0, 0);     // R5 carry, result zero
    apply(3, 64'd5, 64'd5, 0, 0, 0, 0, 0, 0, 0, 0, 0);  // R5 subtract-from equal
    apply(7, MINN, 64'd0, 1, 1, 0, 0, 0, 0, 0, 0, 0);   // R2 negate most negative
    apply(6, '1, 64'd0, 0, 1, 0, 0, 0, 0, 0, 0, 1);     // R2 add-to-zero wraps
    apply(4, 64'h0000_0000_ffff_ffff, 64'd0, 0, 0, 0, 0, 0, 0, 0, 0, 1); // R5 CA32
    apply(8, '1, 64'd0, 1, 1, 1, 0, 0, 0, 0, 1, 0);     // R6 carry into OV
    apply(8, '1, 64'd0, 1, 1, 0, 0, 0, 0, 0, 1, 0);     // R6 select clear
    apply(9, MINN, MAXP, 0, 0, 0, 1, 0, 3'd5, 1, 0, 0); // R8 signed less
    apply(9, MINN, MAXP, 0, 0, 0, 0, 0, 3'd2, 0, 0, 0); // R8 unsigned greater
    apply(9, 64'h1234_0000_0000_0007, 64'h0000_0000_0000_0007, 0, 0, 0, 1, 1, 3'd7, 0, 0, 0); // R8 word equal
    apply(17, '1, 64'h0000_0000_0000_ff00, 0, 0, 0, 0, 0, 0, 0, 0, 0); // R10 record without rc
    apply(13, '1, '1, 0, 1, 0, 0, 0, 0, 1, 0, 0);       // R9 nand gives zero
    apply(20, '1, '1, 1, 1, 1, 0, 0, 0, 1, 1, 1);       // R9 undefined code

    // mid-run reset, R1
    @(negedge clk);
    compareAll();
    havePrev = 0;
    rstN = 1'b0;
    @(negedge clk);
    checkReset();
    rstN = 1'b1;

    for (int i = 0; i < 3000; i++) begin
      int op;
      op = ($urandom_range(0, 15) == 0) ? $urandom_range(18, 31) : $urandom_range(0, 17);
      apply(op, pick(), pick(), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    compareAll();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule